// File: doc/BRIEF.md
# Digit-Broadcast Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns their 2N-bit product. It works sequentially. Operand B is cut into K digits of width D = N/K, and K small digit multipliers work in parallel. On each loop iteration a selector picks one digit of operand A and feeds it to all K multipliers at once. The K double-width digit products form one partial-product row. Adjacent products in the row overlap by one digit, so they are summed with carry rippling. The row is then shifted left by the A-digit index times D bits and added into an accumulator.

A full multiplication takes one operand-load cycle, K loop iterations and one result cycle. The done pulse therefore arrives K+2 clock edges after the start is accepted. A user pulses `start` with both operands while the block is idle, then waits for `done` and reads `product`. The product stays stable until the next accepted start. Choosing a small K gives more parallel hardware and fewer cycles. Choosing K equal to N reduces the loop to shift-and-add with one-bit digits. The default is N=48 with K=3, which gives 16-bit digits. N=192 with K=6 gives 32-bit digits and 64-bit digit products.

Top module: `bcastMul`

## Requirements
- R1: After reset, `done` is 0, `busy` is 0 and `product` is all zeros.
- R2: When `done` is 1, `product` equals the unsigned 2N-bit product of the `opA` and `opB` values sampled on the clock edge that accepted the start.
- R3: `done` rises exactly K+2 rising clock edges after the edge that accepted a start, and it stays high for exactly one cycle.
- R4: A start is accepted only on an edge where `start` is 1 and `busy` is 0. `busy` is 1 from the next cycle until `done` rises, and it is 0 in the cycle in which `done` is 1.
- R5: A `start` pulse seen while `busy` is 1 is ignored. It produces no extra `done` pulse and does not change the product of the operation in flight.
- R6: While the block is idle and `start` is 0, `product` keeps its last value, even if the operand inputs change.
- R7: Changes on `opA` and `opB` after the accepting edge have no effect on the result.
- R8: The product is exact for the corner operands: all zeros, all ones, and a single set bit at the lowest and highest positions.
- R9: The same RTL with N=192 and K=6 (32-bit digits) meets R2 and R3 with a latency of 8 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a multiplication; sampled only when idle |
| opA | input | N | Operand A (unsigned), supplies the broadcast digits |
| opB | input | N | Operand B (unsigned), split across the digit multipliers |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse; product is valid |
| product | output | 2N | Unsigned product, held until the next accepted start |

## Verification
Each result has a fixed latency. `done` and a fresh `product` are due on the (K+2)th rising edge after the accepting edge. `busy` is due on the first edge after it. The bench drives and samples on falling edges. It counts exactly K+2 falling edges after the accepting edge, checking that `done` stays low and `busy` stays high, and then checks `done`, `busy` and `product` on the next falling edge. It checks `done` low again one edge later. For the ignored-start and operand-change cases, the same counted window is used, followed by several extra idle cycles that confirm no second pulse and an unchanged product.

// File: rtl/bcastMulPkg.sv
package bcastMulPkg;

  // Strobes from the sequencer to the datapath, one cycle each
  typedef struct packed {
    logic capture;  // latch operands (start accepted)
    logic clear;    // zero the accumulator
    logic step;     // add one shifted partial-product row
    logic finish;   // move accumulator to the product register
  } mulStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_LOOP = 2'd2,
    ST_FIN  = 2'd3
  } mulState_e;

endpackage

// File: rtl/bcastMulCtrl.sv
module bcastMulCtrl
  import bcastMulPkg::*;
#(
  parameter int K  = 3,
  parameter int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  output mulStrobe_t    strobe,
  output logic [IW-1:0] digitIdx,
  output logic          busy,
  output logic          done
);

  localparam logic [IW-1:0] LastIdx = IW'(K - 1);

  mulState_e state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: if (start) stateNext = ST_LOAD;
      ST_LOAD: stateNext = ST_LOOP;
      ST_LOOP: if (digitIdx == LastIdx) stateNext = ST_FIN;
      ST_FIN:  stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobe.capture = (state == ST_IDLE) && start;
    strobe.clear   = (state == ST_LOAD);
    strobe.step    = (state == ST_LOOP);
    strobe.finish  = (state == ST_FIN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      digitIdx <= '0;
      done     <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_FIN);
      if (state == ST_LOAD)      digitIdx <= '0;
      else if (state == ST_LOOP) digitIdx <= digitIdx + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/bcastMulDatapath.sv
module bcastMulDatapath
  import bcastMulPkg::*;
#(
  parameter int N  = 48,
  parameter int K  = 3,
  parameter int IW = (K > 1) ? $clog2(K) : 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  mulStrobe_t    strobe,
  input  logic [IW-1:0] digitIdx,
  input  logic [N-1:0]  opA,
  input  logic [N-1:0]  opB,
  output logic [2*N-1:0] product
);

  localparam int D  = N / K;     // digit width
  localparam int PW = 2 * D;     // digit product width
  localparam int RW = N + D;     // partial-product row width

  logic [N-1:0]   aReg, bReg;
  logic [2*N-1:0] acc;
  logic [D-1:0]   aDigit;
  logic [PW-1:0]  digitProd [K];
  logic [RW-1:0]  evenRow, oddRow, rowSum;
  logic [2*N-1:0] rowShifted;

  // Broadcast selector: one A digit per iteration
  assign aDigit = aReg[int'(digitIdx) * D +: D];

  // K parallel digit multipliers
  for (genvar j = 0; j < K; j++) begin : gDigitMul
    assign digitProd[j] = PW'(aDigit) * PW'(bReg[j*D +: D]);
  end

  // Even and odd products do not overlap among themselves
  always_comb begin
    evenRow = '0;
    oddRow  = '0;
    for (int j = 0; j < K; j++) begin
      if (j % 2 == 0) evenRow[j*D +: PW] = digitProd[j];
      else            oddRow[j*D +: PW]  = digitProd[j];
    end
  end

  assign rowSum     = evenRow + oddRow;
  assign rowShifted = (2*N)'(rowSum) << (int'(digitIdx) * D);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      aReg    <= '0;
      bReg    <= '0;
      acc     <= '0;
      product <= '0;
    end else begin
      if (strobe.capture) begin
        aReg <= opA;
        bReg <= opB;
      end
      if (strobe.clear)      acc <= '0;
      else if (strobe.step)  acc <= acc + rowShifted;
      if (strobe.finish)     product <= acc;
    end
  end

endmodule

// File: rtl/bcastMul.sv
module bcastMul
  import bcastMulPkg::*;
#(
  parameter int N = 48,
  parameter int K = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           start,
  input  logic [N-1:0]   opA,
  input  logic [N-1:0]   opB,
  output logic           busy,
  output logic           done,
  output logic [2*N-1:0] product
);

  localparam int IW = (K > 1) ? $clog2(K) : 1;

  mulStrobe_t    strobe;
  logic [IW-1:0] digitIdx;

  bcastMulCtrl #(.K(K), .IW(IW)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(strobe), .digitIdx(digitIdx), .busy(busy), .done(done)
  );

  bcastMulDatapath #(.N(N), .K(K), .IW(IW)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .digitIdx(digitIdx),
    .opA(opA), .opB(opB), .product(product)
  );

endmodule

// File: rtl/bcastMulChecker.sv
module bcastMulChecker #(
  parameter int N = 48,
  parameter int K = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           start,
  input logic [N-1:0]   opA,
  input logic [N-1:0]   opB,
  input logic           busy,
  input logic           done,
  input logic [2*N-1:0] product
);

  localparam int LAT = K + 2;

  logic [31:0]    cnt;
  logic [2*N-1:0] expProd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      expProd <= '0;
    end else if (start && !busy) begin
      cnt     <= 32'd1;
      expProd <= (2*N)'(opA) * (2*N)'(opB);
    end else if (busy) begin
      cnt <= cnt + 32'd1;
    end
  end

  assert_product_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> product == expProd);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |-> cnt == 32'(LAT + 1));

  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_accept_R4: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  assert_idle_at_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !start) |=> $stable(product));

endmodule

bind bcastMul bcastMulChecker #(.N(N), .K(K)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
  .busy(busy), .done(done), .product(product)
);

// File: tb/sim_bcastMul.sv
`timescale 1ns/1ps
module sim_bcastMul;

  localparam int NA = 48,  KA = 3;
  localparam int NB = 192, KB = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic            startA = 1'b0;
  logic [NA-1:0]   aA = '0, bA = '0;
  logic            busyA, doneA;
  logic [2*NA-1:0] prodA;

  logic            startB = 1'b0;
  logic [NB-1:0]   aB = '0, bB = '0;
  logic            busyB, doneB;
  logic [2*NB-1:0] prodB;

  int nChecks = 0;
  int nFails  = 0;

  bcastMul #(.N(NA), .K(KA)) u0 (
    .clk(clk), .rstN(rstN), .start(startA), .opA(aA), .opB(bA),
    .busy(busyA), .done(doneA), .product(prodA)
  );

  bcastMul #(.N(NB), .K(KB)) u1 (
    .clk(clk), .rstN(rstN), .start(startB), .opA(aB), .opB(bB),
    .busy(busyB), .done(doneB), .product(prodB)
  );

  task automatic check(input logic ok, input string req,
                       input logic [2*NB-1:0] act, input logic [2*NB-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One multiplication on u0 with exact latency and result checks
  task automatic runA(input logic [NA-1:0] a, input logic [NA-1:0] b, input string req);
    logic [2*NA-1:0] exp = (2*NA)'(a) * (2*NA)'(b);
    logic windowOk = 1'b1;
    @(negedge clk); aA = a; bA = b; startA = 1'b1;
    @(negedge clk); startA = 1'b0;
    for (int c = 1; c <= KA + 2; c++) begin
      if (doneA || !busyA) windowOk = 1'b0;
      @(negedge clk);
    end
    check(windowOk, {req, " R3 R4 window"}, {doneA, busyA}, 2'b01);
    check(doneA && !busyA, {req, " R3 done due"}, {doneA, busyA}, 2'b10);
    check(prodA == exp, {req, " R2 product"}, prodA, exp);
    @(negedge clk);
    check(!doneA, {req, " R3 one-cycle done"}, doneA, 0);
  endtask

  task automatic runB(input logic [NB-1:0] a, input logic [NB-1:0] b, input string req);
    logic [2*NB-1:0] exp = (2*NB)'(a) * (2*NB)'(b);
    logic windowOk = 1'b1;
    @(negedge clk); aB = a; bB = b; startB = 1'b1;
    @(negedge clk); startB = 1'b0;
    for (int c = 1; c <= KB + 2; c++) begin
      if (doneB || !busyB) windowOk = 1'b0;
      @(negedge clk);
    end
    check(windowOk, {req, " R9 window"}, {doneB, busyB}, 2'b01);
    check(doneB && !busyB, {req, " R9 done due"}, {doneB, busyB}, 2'b10);
    check(prodB == exp, {req, " R9 product"}, prodB, exp);
    @(negedge clk);
    check(!doneB, {req, " R9 one-cycle done"}, doneB, 0);
  endtask

  task automatic testReset();
    check(!doneA && !busyA, "R1 u0 flags", {doneA, busyA}, 0);
    check(prodA == '0, "R1 u0 product", prodA, 0);
    check(!doneB && !busyB && prodB == '0, "R1 u1 state", prodB, 0);
  endtask

  task automatic testCorners();
    runA('0, '0, "R8 zeros");
    runA('1, '1, "R8 ones");
    runA(48'h1, '1, "R8 lsb x ones");
    runA(48'h8000_0000_0000, 48'h8000_0000_0000, "R8 msb x msb");
    runA('1, '0, "R8 ones x zero");
  endtask

  task automatic testRandom();
    for (int i = 0; i < 20; i++)
      runA({$urandom, $urandom}, {$urandom, $urandom}, "R2 random");
  endtask

  // Start while busy plus operand changes mid-flight
  task automatic testIgnoredStart();
    logic [NA-1:0] a1 = 48'hBEEF_1234_5678, b1 = 48'h0F0F_A5A5_3C3C;
    logic [2*NA-1:0] exp = (2*NA)'(a1) * (2*NA)'(b1);
    int doneCount = 0;
    @(negedge clk); aA = a1; bA = b1; startA = 1'b1;
    @(negedge clk); startA = 1'b0;
    @(negedge clk); startA = 1'b1; aA = '1; bA = 48'h1234;
    @(negedge clk); startA = 1'b0; aA = 48'h5; bA = 48'h7;
    for (int c = 3; c <= KA + 2; c++) @(negedge clk);
    check(doneA, "R5 done on time", doneA, 1);
    check(prodA == exp, "R5 R7 product of first operands", prodA, exp);
    for (int c = 0; c < 8; c++) begin
      @(negedge clk);
      if (doneA) doneCount++;
    end
    check(doneCount == 0, "R5 no extra done", doneCount, 0);
    check(prodA == exp, "R6 product held after done", prodA, exp);
  endtask

  task automatic testHold();
    logic [2*NA-1:0] held = prodA;
    @(negedge clk); aA = 48'h1111; bA = 48'h2222;
    for (int c = 0; c < 5; c++) @(negedge clk);
    check(prodA == held && !busyA, "R6 idle hold", prodA, held);
  endtask

  task automatic testWide();
    runB('1, '1, "R9 ones");
    runB({1'b1, 191'b0}, 192'h3, "R9 msb x 3");
    for (int i = 0; i < 5; i++)
      runB({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom}, "R9 random");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testCorners();
    testRandom();
    testIgnoredStart();
    testHold();
    testWide();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule